// File: doc/BRIEF.md
# Daisy-Chainable SPI Configuration Register Slave

This block is the serial front end of a configuration and status register file. A host talks to it over four wires: an active-low chip select, a serial clock, serial data in and serial data out. Data out comes with an output-enable that a pad cell uses to tri-state the pin. A frame is one or more 16-bit words sent MSB first. While chip select is low, the block shifts the host's bits in. At the same time it shifts out a readback word, chosen by an earlier selection write. Once the first 16 bits of a frame are out, serial out repeats what came in on serial in. Several slaves can therefore share one chip select in a chain, and the host can check each message by its echo.

When chip select goes high, the block accepts the frame only if it carried a whole, nonzero number of 16-bit words. The last word received is then decoded as a 5-bit address in bits 15:11 and an 11-bit data field in bits 10:0, and the addressed register is written. The block then drives the stored settings to the rest of the chip. A frame of any other length leaves every register and the readback selection as they were.

Everything runs on the system clock `clk`. The serial inputs are taken as already synchronised to `clk`, and each serial clock level must last at least two `clk` cycles.

The controller is a three-state machine:
- **IDLE** is left by the *start* transition when `cs_n` is low. On that transition the readback word is loaded.
- **SHIFT** moves bits. It is left by the *close* transition when `cs_n` is high.
- **DONE** lasts one cycle. The frame is judged there and the write is issued if the frame is valid. It then takes the *retire* transition back to IDLE.

Top module: `spi_rf_slave`

## Requirements
- R1: After reset, `sdo_oe` is 0, `glob_cfg`, `ch_cfg` and `cal_cfg` are all zero, and the readback selection is code 0 with channel 0, so the first frame returns 16'h0000.
- R2: At frame start the readback word is loaded, and `sdo` presents its bit 15 before the first rising `sclk` edge. `sdo` moves to the next bit on each falling `sclk` edge and otherwise holds, so a host that samples on rising edges reads the word MSB first.
- R3: From the 17th `sclk` rising edge of a frame onward, the bit seen on `sdo` is the `sdi` bit received 16 rising edges earlier.
- R4: `sdo_oe` is 1 from one cycle after `cs_n` falls until `cs_n` rises, and 0 in every cycle in which `cs_n` has been high for two consecutive cycles.
- R5: A frame whose rising-edge count is zero or not a multiple of 16 changes no register and no readback selection.
- R6: A valid frame writes its last 16 received bits: address in bits 15:11, data in bits 10:0. The configuration outputs change only on the clock edge that retires the frame, within three `clk` cycles of `cs_n` rising.
- R7: Address 5'h05 is the global configuration register. It stores data bits 8:2 and bit 0, and `glob_cfg[1]` stays 0. In `glob_cfg`, bit 8 enables the supply-fail transition, bit 7 enables the PWM, bit 6 selects the PWM clock, bits 5:4 select the current-sense mode, bits 3:2 select the sensed channel, and bit 0 selects the over-current mode.
- R8: Address 5'h01 writes a per-output register. Data bits 10:9 name the output n and bits 8:0 are the value, which appears at `ch_cfg[9n+8:9n]`.
- R9: Address 5'h07 is the calibration register. It stores all 11 data bits, which appear on `cal_cfg`.
- R10: Address 5'h00 sets the readback selection: code in data bits 4:0, output channel c in data bits 6:5. The selection takes effect from the next frame and holds until replaced. The readback word is {code, payload}, where the payload is:
  - for code 0: {4'b0, c, code};
  - for code 1: {c, per-output value of channel c};
  - for code 5: {2'b0, `glob_cfg`};
  - for code 7: `cal_cfg`;
  - for any other code: zero.
- R11: A write to any address other than 5'h00, 5'h01, 5'h05 or 5'h07 changes nothing.
- R12: Frame length is judged correctly for arbitrarily long chains: a 320-bit frame is valid and a 321-bit frame is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| sclk | input | 1 | Serial clock, idle low, synchronous to clk |
| sdi | input | 1 | Serial data in, sampled on rising sclk |
| sdo | output | 1 | Serial data out, changes on falling sclk |
| sdo_oe | output | 1 | Output enable for the sdo pad (tri-state when 0) |
| glob_cfg | output | 9 | Global configuration fields |
| ch_cfg | output | NUM_CH*(WORD_W-5-log2(NUM_CH)) | Per-output values, channel n at slice n |
| cal_cfg | output | WORD_W-5 | Calibration value |

## Verification
The bench builds the block with the default WORD_W of 16 and NUM_CH of 4. This gives an 11-bit data field, so every global field bit position and all four per-output slots can be written and read back through the chosen selection. With these widths the 4-bit position counter wraps twenty times in a 320-bit chain, which exposes the sticky word flag, and frames of 0, 15, 17 and 321 bits cover every rejection path. The scoreboard predicts each `sdo` bit, for both the readback portion and the echoed portion, from a register model that is updated only by frames the requirements call valid.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;

    localparam int ADDR_W = 5;
    localparam int GLOB_W = 9;

    localparam logic [ADDR_W-1:0] A_SELECT = 5'h00;
    localparam logic [ADDR_W-1:0] A_CHCFG  = 5'h01;
    localparam logic [ADDR_W-1:0] A_GLOBAL = 5'h05;
    localparam logic [ADDR_W-1:0] A_CALIB  = 5'h07;

    // bit 1 of the global register is unused and reads as zero
    localparam logic [GLOB_W-1:0] GLOB_MASK = 9'h1FD;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } frm_state_e;

endpackage

// File: rtl/spi_rf_frame.sv
module spi_rf_frame
    import spi_rf_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic [WORD_W-1:0] rd_word,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_word,
    output frm_state_e        state_o,
    output logic              sclk_fall_o
);
    localparam int CNT_W = $clog2(WORD_W);

    frm_state_e        state, nxt_state;
    logic              load;
    logic              sclk_q;
    logic              sclk_rise, sclk_fall;
    logic [WORD_W-1:0] sr;
    logic              so_q;
    logic [CNT_W-1:0]  pos;
    logic              got_word;

    assign sclk_rise = sclk & ~sclk_q & ~cs_n & (state == ST_SHIFT);
    assign sclk_fall = ~sclk & sclk_q & ~cs_n & (state == ST_SHIFT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // transitions: start, close, retire
    always_comb begin
        nxt_state = state;
        load      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (!cs_n) begin
                    nxt_state = ST_SHIFT;
                    load      = 1'b1;
                end
            end
            ST_SHIFT: if (cs_n) nxt_state = ST_DONE;
            ST_DONE:  nxt_state = ST_IDLE;
            default:  nxt_state = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        sdo_oe = (state == ST_SHIFT);
        wr_en  = (state == ST_DONE) && got_word && (pos == '0);
    end

    // shift path: one register carries readback, received word and echo
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            sr       <= '0;
            so_q     <= 1'b0;
            pos      <= '0;
            got_word <= 1'b0;
        end else begin
            sclk_q <= sclk;
            if (load) begin
                sr       <= rd_word;
                so_q     <= rd_word[WORD_W-1];
                pos      <= '0;
                got_word <= 1'b0;
            end else if (sclk_rise) begin
                sr  <= {sr[WORD_W-2:0], sdi};
                pos <= pos + 1'b1;
                if (pos == CNT_W'(WORD_W - 1)) got_word <= 1'b1;
            end else if (sclk_fall) begin
                so_q <= sr[WORD_W-1];
            end
        end
    end

    assign sdo         = so_q;
    assign wr_word     = sr;
    assign state_o     = state;
    assign sclk_fall_o = sclk_fall;

endmodule

// File: rtl/spi_rf_regs.sv
module spi_rf_regs
    import spi_rf_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int NUM_CH = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [WORD_W-1:0]               wr_word,
    output logic [WORD_W-1:0]               rd_word,
    output logic [GLOB_W-1:0]               glob_cfg,
    output logic [NUM_CH*(WORD_W-ADDR_W-$clog2(NUM_CH))-1:0] ch_cfg,
    output logic [WORD_W-ADDR_W-1:0]        cal_cfg
);
    localparam int DATA_W = WORD_W - ADDR_W;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int VAL_W  = DATA_W - CH_W;

    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W-1:0] sel_code;
    logic [CH_W-1:0]   sel_ch;
    logic [VAL_W-1:0]  ch_pick;
    logic [DATA_W-1:0] payload;

    assign wr_addr = wr_word[WORD_W-1 -: ADDR_W];
    assign wr_data = wr_word[DATA_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_code <= '0;
            sel_ch   <= '0;
            glob_cfg <= '0;
            cal_cfg  <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_SELECT: begin
                    sel_code <= wr_data[ADDR_W-1:0];
                    sel_ch   <= wr_data[ADDR_W +: CH_W];
                end
                A_GLOBAL: glob_cfg <= wr_data[GLOB_W-1:0] & GLOB_MASK;
                A_CALIB:  cal_cfg  <= wr_data;
                default: ;
            endcase
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [VAL_W-1:0] val;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                val <= '0;
            else if (wr_en && wr_addr == A_CHCFG &&
                     wr_data[DATA_W-1 -: CH_W] == CH_W'(c))
                val <= wr_data[VAL_W-1:0];
        end
        assign ch_cfg[c*VAL_W +: VAL_W] = val;
    end

    assign ch_pick = ch_cfg[sel_ch*VAL_W +: VAL_W];

    always_comb begin
        unique case (sel_code)
            A_SELECT: payload = DATA_W'({sel_ch, sel_code});
            A_CHCFG:  payload = {sel_ch, ch_pick};
            A_GLOBAL: payload = DATA_W'(glob_cfg);
            A_CALIB:  payload = cal_cfg;
            default:  payload = '0;
        endcase
    end

    assign rd_word = {sel_code, payload};

endmodule

// File: rtl/spi_rf_slave.sv
module spi_rf_slave
    import spi_rf_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int NUM_CH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        sclk,
    input  logic        sdi,
    output logic        sdo,
    output logic        sdo_oe,
    output logic [spi_rf_pkg::GLOB_W-1:0] glob_cfg,
    output logic [NUM_CH*(WORD_W-spi_rf_pkg::ADDR_W-$clog2(NUM_CH))-1:0] ch_cfg,
    output logic [WORD_W-spi_rf_pkg::ADDR_W-1:0] cal_cfg
);
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] wr_word;
    logic              wr_en;
    frm_state_e        frm_state;
    logic              sclk_fall;

    spi_rf_frame #(.WORD_W(WORD_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .sdi         (sdi),
        .rd_word     (rd_word),
        .sdo         (sdo),
        .sdo_oe      (sdo_oe),
        .wr_en       (wr_en),
        .wr_word     (wr_word),
        .state_o     (frm_state),
        .sclk_fall_o (sclk_fall)
    );

    spi_rf_regs #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_word  (wr_word),
        .rd_word  (rd_word),
        .glob_cfg (glob_cfg),
        .ch_cfg   (ch_cfg),
        .cal_cfg  (cal_cfg)
    );

endmodule

// File: rtl/spi_rf_slave_chk.sv
module spi_rf_slave_chk
    import spi_rf_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int NUM_CH = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sdo,
    input logic       sdo_oe,
    input logic       wr_en,
    input logic       sclk_fall,
    input frm_state_e frm_state,
    input logic [GLOB_W-1:0] glob_cfg,
    input logic [NUM_CH*(WORD_W-ADDR_W-$clog2(NUM_CH))-1:0] ch_cfg,
    input logic [WORD_W-ADDR_W-1:0] cal_cfg
);
    // R4: pad released once chip select has been high two cycles
    a_r4_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !sdo_oe);

    // R4: no drive while a write is being committed
    a_r4_oe_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !sdo_oe);

    // R6: one write per frame
    a_r6_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R5: configuration moves only after a commit
    a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> ($stable(glob_cfg) && $stable(ch_cfg) && $stable(cal_cfg)));

    // R2: inside a frame sdo moves only after a falling serial clock
    a_r2_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_state == ST_SHIFT && $past(frm_state) == ST_SHIFT && !$past(sclk_fall))
        |-> $stable(sdo));

endmodule

bind spi_rf_slave spi_rf_slave_chk #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .wr_en     (wr_en),
    .sclk_fall (sclk_fall),
    .frm_state (frm_state),
    .glob_cfg  (glob_cfg),
    .ch_cfg    (ch_cfg),
    .cal_cfg   (cal_cfg)
);

// File: tb/spi_rf_slave_tb.sv
module spi_rf_slave_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo, sdo_oe;
    logic [8:0]  glob_cfg;
    logic [35:0] ch_cfg;
    logic [10:0] cal_cfg;

    int ntests = 0;
    int nfail  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    spi_rf_slave u_dut (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sclk (sclk), .sdi (sdi),
        .sdo (sdo), .sdo_oe (sdo_oe), .glob_cfg (glob_cfg),
        .ch_cfg (ch_cfg), .cal_cfg (cal_cfg)
    );

    typedef struct { logic b; string req; } exp_t;
    exp_t exp_q[$];

    // reference model
    logic [8:0]  m_glob;
    logic [8:0]  m_ch [4];
    logic [10:0] m_cal;
    logic [4:0]  m_code;
    logic [1:0]  m_sch;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mkw(input logic [4:0] a, input logic [10:0] d);
        return {a, d};
    endfunction

    function automatic logic [15:0] exp_rb();
        case (m_code)
            5'd0:    return {5'd0, 4'd0, m_sch, m_code};
            5'd1:    return {5'd1, m_sch, m_ch[m_sch]};
            5'd5:    return {5'd5, 2'b00, m_glob};
            5'd7:    return {5'd7, m_cal};
            default: return {m_code, 11'd0};
        endcase
    endfunction

    task automatic model_write(input logic [15:0] w);
        case (w[15:11])
            5'h00: begin m_code = w[4:0]; m_sch = w[6:5]; end
            5'h01: m_ch[w[10:9]] = w[8:0];
            5'h05: m_glob = w[8:0] & 9'h1FD;
            5'h07: m_cal = w[10:0];
            default: ;
        endcase
    endtask

    task automatic check_cfg(input string req);
        chk(req, {23'd0, glob_cfg}, {23'd0, m_glob});
        chk(req, {21'd0, cal_cfg}, {21'd0, m_cal});
        for (int c = 0; c < 4; c++)
            chk(req, {23'd0, ch_cfg[c*9 +: 9]}, {23'd0, m_ch[c]});
        chk("R4", {31'd0, sdo_oe}, 32'd0);
    endtask

    // driver: predicts sdo bits, then clocks the frame
    task automatic spi_xfer(input logic [511:0] tx, input int nbits, input string req);
        logic [15:0] rb;
        rb = exp_rb();
        for (int i = 0; i < nbits; i++) begin
            exp_t e;
            if (i < 16) begin e.b = rb[15-i];           e.req = "R2"; end
            else        begin e.b = tx[nbits-1-(i-16)]; e.req = "R3"; end
            exp_q.push_back(e);
        end
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = tx[nbits-1-i];
            repeat (2) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2", exp_q.size(), 0);
        exp_q.delete();
        if (nbits > 0 && nbits % 16 == 0) model_write(tx[15:0]);
        check_cfg(req);
    endtask

    // monitor: compares each bit the host samples on rising sclk
    always @(posedge sclk) begin
        exp_t e;
        if (exp_q.size() == 0) begin
            ntests++; nfail++;
            $display("FAIL R2 unexpected bit actual=%0b expected=none", sdo);
        end else begin
            e = exp_q.pop_front();
            chk(e.req, {31'd0, sdo}, {31'd0, e.b});
            chk("R4", {31'd0, sdo_oe}, 32'd1);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            ntests++; nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

    initial begin
        logic [511:0] tx;
        m_glob = '0; m_cal = '0; m_code = '0; m_sch = '0;
        for (int c = 0; c < 4; c++) m_ch[c] = '0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_cfg("R1");

        // R7 with R1 readback of 0000
        spi_xfer(512'(mkw(5'h05, 11'h1FF)), 16, "R7");
        // R10 select global
        spi_xfer(512'(mkw(5'h00, {4'd0, 2'd0, 5'd5})), 16, "R10");
        // R8 per-output writes
        spi_xfer(512'(mkw(5'h01, {2'd2, 9'h0A5})), 16, "R8");
        spi_xfer(512'(mkw(5'h01, {2'd1, 9'h1C3})), 16, "R8");
        spi_xfer(512'(mkw(5'h01, {2'd3, 9'h111})), 16, "R8");
        spi_xfer(512'(mkw(5'h00, {4'd0, 2'd2, 5'd1})), 16, "R10");
        // R9 calibration, readback of channel 2
        spi_xfer(512'(mkw(5'h07, 11'h5A3)), 16, "R9");
        // R5 invalid lengths
        spi_xfer(512'(mkw(5'h05, 11'h000) >> 1), 15, "R5");
        spi_xfer({495'd0, 1'b1, mkw(5'h05, 11'h000)}, 17, "R5");
        spi_xfer('0, 0, "R5");
        spi_xfer({495'd0, 1'b0, mkw(5'h00, {4'd0, 2'd1, 5'd7})}, 17, "R5");
        // R10 selection survived the invalid frames: reads channel 2 again
        spi_xfer(512'(mkw(5'h00, {4'd0, 2'd1, 5'd1})), 16, "R10");
        // R3 two-word chain; last word selects calibration
        spi_xfer(512'({mkw(5'h1F, 11'h6DB), mkw(5'h00, {4'd0, 2'd0, 5'd7})}), 32, "R3");
        // R11 undefined addresses
        spi_xfer(512'(mkw(5'h1F, 11'h7FF)), 16, "R11");
        spi_xfer(512'(mkw(5'h0A, 11'h7FF)), 16, "R11");
        // R10 undefined code reads zero payload
        spi_xfer(512'(mkw(5'h00, {4'd0, 2'd3, 5'h0A})), 16, "R10");
        spi_xfer(512'(mkw(5'h00, {4'd0, 2'd3, 5'd0})), 16, "R10");
        // R12 long chain, valid and one bit too many
        tx = '0;
        for (int i = 1; i < 20; i++) tx[i*16 +: 16] = mkw(5'h1F, 11'(i));
        tx[15:0] = mkw(5'h05, 11'h0C3);
        spi_xfer(tx, 320, "R12");
        tx[15:0] = mkw(5'h05, 11'h1FF);
        tx[320]  = 1'b1;
        spi_xfer(tx, 321, "R12");
        spi_xfer(512'(mkw(5'h00, {4'd0, 2'd0, 5'd5})), 16, "R12");
        spi_xfer(512'(mkw(5'h1F, 11'h000)), 16, "R10");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule